// File: doc/BRIEF.md
# Trace-Table Affine Coordinate Walker

This block produces source-image coordinates for a rotate-and-scale engine. It covers a rectangular destination region one line at a time. For each destination line it reads a four-word descriptor from a trace table in a 16-bit word memory. The descriptor gives a fixed-point start position and a signed per-pixel step. The block then walks that position across the line and emits one integer source coordinate pair per destination pixel. Each pair comes with a running destination pixel index. Downstream logic turns these coordinates into stamp lookups, pixel fetches and writebacks.

Software sets three values: the region width in pixels, the height in lines, and the first destination index. Writing the trace table base address launches the operation. A status word reports whether the walk is still running. The memory port is strictly sequential and slow: every word read occupies the port for three cycles. Coordinate pairs leave through a valid/ready handshake, so a slow consumer stalls the walk without losing pixels.

Top module: `affine_trace_walker`

## Requirements
- R1: Descriptor n of an operation starts at word address base + 4*n. Its words, in address order, are start X, start Y, step X, step Y.
- R2: A start word is unsigned, with 13 integer bits and 3 fraction bits. It is aligned to a 24-bit accumulator (13 integer bits, 11 fraction bits) by appending 8 zero bits. The first pixel of a line emits the start word's integer part, which is word >> 3.
- R3: A step word is sign-magnitude. Bit 15 set means negative, and bits 14:0 are the magnitude in units of 2^-11. The magnitude is added to or subtracted from the 24-bit accumulator modulo 2^24. The emitted coordinate is accumulator bits 23:11.
- R4: Each line emits exactly width pixels. Every pixel after the first is the previous position plus the step.
- R5: After the last pixel of a line the next descriptor is fetched, and no pixel is offered while a fetch runs. After height lines the walk stops and busy clears.
- R6: Once pix_valid is high it stays high, and the coordinates and index stay unchanged, until pix_ready accepts the pixel. The accumulators advance only on acceptance.
- R7: Config selects are 0 = width, 1 = height, 2 = first destination index, 3 = base (the launch). Status bit 15 is 1 while busy, and the other status bits read 0. When idle, pix_valid and mem_rd stay low.
- R8: Each word read holds mem_rd and mem_addr for 3 cycles and samples mem_rdata in the third cycle. The first pixel is therefore offered on the 12th cycle after the launch edge.
- R9: The destination index starts at the programmed first index and increases by 1 per accepted pixel across all lines, which is row-major order with a stride equal to the width.
- R10: A base write while busy is ignored. Width, height and first index are captured at launch, so writes to them during a walk do not affect that walk.
- R11: A base write while width or height is zero does not launch: busy stays 0 and nothing is fetched or emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Config write strobe |
| cfg_sel | input | 2 | Config register select |
| cfg_wdata | input | 16 | Config write data |
| stat_word | output | 16 | Status word, bit 15 = busy |
| busy | output | 1 | Walk in progress |
| mem_rd | output | 1 | Trace memory read request |
| mem_addr | output | ADDR_W | Trace memory word address |
| mem_rdata | input | 16 | Trace memory read data |
| pix_valid | output | 1 | Coordinate pair available |
| pix_ready | input | 1 | Consumer accepts the pair |
| pix_src_x | output | 13 | Source X integer part |
| pix_src_y | output | 13 | Source Y integer part |
| pix_dst | output | DST_W | Destination pixel index |

## Verification
The hardest conditions to reach from the ports are accumulator wrap-around in both directions and a consumer stall on the last pixel of a line, just before a descriptor fetch. The stimulus uses start positions at 0 and 8191 with steps of the opposite sign, and a pseudo-random ready pattern that stalls at line ends. A second walk receives a base write and a width write in the middle of its run. A scoreboard built from the descriptor table confirms that neither write changes the output sequence.

// File: rtl/atw_pkg.sv
package atw_pkg;
    localparam int WORD_W      = 16;
    localparam int ACC_W       = 24;
    localparam int INT_W       = 13;
    localparam int FRAC_W      = ACC_W - INT_W;
    localparam int START_FRAC  = 3;
    localparam int START_PAD   = FRAC_W - START_FRAC;
    localparam int MAG_W       = WORD_W - 1;
    localparam int ENTRY_WORDS = 4;
    localparam int ACCESS_CYC  = 3;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FETCH = 2'd1,
        PH_LINE  = 2'd2
    } phase_e;

    typedef struct packed {
        logic [WORD_W-1:0] sx;
        logic [WORD_W-1:0] sy;
        logic [WORD_W-1:0] dx;
        logic [WORD_W-1:0] dy;
    } entry_t;
endpackage

// File: rtl/atw_fetch.sv
module atw_fetch
    import atw_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] entry_addr,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              done,
    output entry_t            entry
);
    localparam int CYC_W  = $clog2(ACCESS_CYC);
    localparam int WORD_IW = $clog2(ENTRY_WORDS);

    typedef struct packed {
        logic               active;
        logic [CYC_W-1:0]   cyc;
        logic [WORD_IW-1:0] widx;
        logic [ADDR_W-1:0]  addr;
        entry_t             ent;
    } fetch_s;

    fetch_s fs_d, fs_q;
    logic   last_cyc;

    always_comb begin
        fs_d     = fs_q;
        last_cyc = fs_q.active && (fs_q.cyc == CYC_W'(ACCESS_CYC - 1));
        done     = last_cyc && (fs_q.widx == WORD_IW'(ENTRY_WORDS - 1));
        if (start) begin
            fs_d.active = 1'b1;
            fs_d.cyc    = '0;
            fs_d.widx   = '0;
            fs_d.addr   = entry_addr;
        end else if (fs_q.active) begin
            if (last_cyc) begin
                fs_d.cyc = '0;
                case (fs_q.widx)
                    2'd0:    fs_d.ent.sx = mem_rdata;
                    2'd1:    fs_d.ent.sy = mem_rdata;
                    2'd2:    fs_d.ent.dx = mem_rdata;
                    default: fs_d.ent.dy = mem_rdata;
                endcase
                fs_d.widx = fs_q.widx + 1'b1;
                fs_d.addr = fs_q.addr + 1'b1;
                if (done) begin
                    fs_d.active = 1'b0;
                end
            end else begin
                fs_d.cyc = fs_q.cyc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q <= '0;
        end else begin
            fs_q <= fs_d;
        end
    end

    assign mem_rd   = fs_q.active;
    assign mem_addr = fs_q.addr;
    assign entry    = fs_q.ent;

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && fs_q.cyc != '0) |-> ($stable(mem_addr) && $past(mem_rd))); // R8
endmodule

// File: rtl/atw_axis.sv
module atw_axis
    import atw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] start_word,
    input  logic              step,
    input  logic [WORD_W-1:0] delta_word,
    output logic [INT_W-1:0]  coord
);
    logic [ACC_W-1:0] acc_d, acc_q;
    logic [ACC_W-1:0] mag;

    always_comb begin
        mag   = {{(ACC_W-MAG_W){1'b0}}, delta_word[MAG_W-1:0]};
        acc_d = acc_q;
        if (load) begin
            acc_d = {start_word, {START_PAD{1'b0}}};
        end else if (step) begin
            if (delta_word[WORD_W-1]) begin
                acc_d = acc_q - mag;
            end else begin
                acc_d = acc_q + mag;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign coord = acc_q[ACC_W-1:FRAC_W];

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(coord)); // R6
endmodule

// File: rtl/affine_trace_walker.sv
module affine_trace_walker
    import atw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 9,
    parameter int DST_W  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       stat_word,
    output logic              busy,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [15:0]       mem_rdata,
    output logic              pix_valid,
    input  logic              pix_ready,
    output logic [12:0]       pix_src_x,
    output logic [12:0]       pix_src_y,
    output logic [DST_W-1:0]  pix_dst
);
    localparam logic [1:0] SEL_WIDTH  = 2'd0;
    localparam logic [1:0] SEL_HEIGHT = 2'd1;
    localparam logic [1:0] SEL_OFFS   = 2'd2;
    localparam logic [1:0] SEL_BASE   = 2'd3;

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  prog_w;
        logic [CNT_W-1:0]  prog_h;
        logic [DST_W-1:0]  prog_offs;
        logic [CNT_W-1:0]  run_w;
        logic [CNT_W-1:0]  run_h;
        logic [CNT_W-1:0]  px;
        logic [CNT_W-1:0]  line;
        logic [DST_W-1:0]  dst;
        logic [ADDR_W-1:0] ent_addr;
    } ctl_s;

    ctl_s              c_d, c_q;
    logic              fetch_start;
    logic [ADDR_W-1:0] fetch_addr;
    logic              fetch_done;
    entry_t            entry;
    logic              accept;
    logic              axis_load;
    logic              axis_step;

    always_comb begin
        c_d         = c_q;
        fetch_start = 1'b0;
        fetch_addr  = c_q.ent_addr;
        accept      = (c_q.phase == PH_LINE) && pix_ready;
        axis_load   = 1'b0;
        axis_step   = accept;

        if (cfg_wr) begin
            case (cfg_sel)
                SEL_WIDTH:  c_d.prog_w    = cfg_wdata[CNT_W-1:0];
                SEL_HEIGHT: c_d.prog_h    = cfg_wdata[CNT_W-1:0];
                SEL_OFFS:   c_d.prog_offs = DST_W'(cfg_wdata);
                default:    ;
            endcase
        end

        case (c_q.phase)
            PH_IDLE: begin
                if (cfg_wr && cfg_sel == SEL_BASE &&
                    c_q.prog_w != '0 && c_q.prog_h != '0) begin
                    fetch_start = 1'b1;
                    fetch_addr  = cfg_wdata[ADDR_W-1:0];
                    c_d.phase    = PH_FETCH;
                    c_d.run_w    = c_q.prog_w;
                    c_d.run_h    = c_q.prog_h;
                    c_d.dst      = c_q.prog_offs;
                    c_d.px       = '0;
                    c_d.line     = '0;
                    c_d.ent_addr = cfg_wdata[ADDR_W-1:0];
                end
            end
            PH_FETCH: begin
                if (fetch_done) begin
                    axis_load = 1'b1;
                    c_d.phase = PH_LINE;
                    c_d.px    = '0;
                end
            end
            default: begin
                if (accept) begin
                    c_d.dst = c_q.dst + 1'b1;
                    if (c_q.px == c_q.run_w - 1'b1) begin
                        c_d.px = '0;
                        if (c_q.line == c_q.run_h - 1'b1) begin
                            c_d.phase = PH_IDLE;
                        end else begin
                            c_d.line     = c_q.line + 1'b1;
                            c_d.ent_addr = c_q.ent_addr + ADDR_W'(ENTRY_WORDS);
                            fetch_addr   = c_q.ent_addr + ADDR_W'(ENTRY_WORDS);
                            fetch_start  = 1'b1;
                            c_d.phase    = PH_FETCH;
                        end
                    end else begin
                        c_d.px = c_q.px + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.phase <= PH_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    atw_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (fetch_start),
        .entry_addr (fetch_addr),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .done       (fetch_done),
        .entry      (entry)
    );

    atw_axis u_axis_x (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (axis_load),
        .start_word (entry.sx),
        .step       (axis_step),
        .delta_word (entry.dx),
        .coord      (pix_src_x)
    );

    atw_axis u_axis_y (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (axis_load),
        .start_word (entry.sy),
        .step       (axis_step),
        .delta_word (entry.dy),
        .coord      (pix_src_y)
    );

    assign busy      = (c_q.phase != PH_IDLE);
    assign stat_word = {busy, 15'd0};
    assign pix_valid = (c_q.phase == PH_LINE);
    assign pix_dst   = c_q.dst;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pix_valid && !mem_rd)); // R7
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> !mem_rd); // R5
    AST_PIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_src_x) &&
                                       $stable(pix_src_y) && $stable(pix_dst))); // R6
    AST_DST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_ready) |=> (pix_dst == $past(pix_dst) + 1'b1)); // R9
endmodule

// File: tb/tb_affine_trace_walker.sv
module tb_affine_trace_walker;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int DST_W  = 17;

    typedef struct packed {
        logic [12:0]      x;
        logic [12:0]      y;
        logic [DST_W-1:0] d;
    } pix_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [1:0]        cfg_sel = '0;
    logic [15:0]       cfg_wdata = '0;
    logic [15:0]       stat_word;
    logic              busy;
    logic              mem_rd;
    logic [ADDR_W-1:0] mem_addr;
    logic [15:0]       mem_rdata;
    logic              pix_valid;
    logic              pix_ready = 1'b1;
    logic [12:0]       pix_src_x;
    logic [12:0]       pix_src_y;
    logic [DST_W-1:0]  pix_dst;

    logic [15:0] mem [0:255];
    pix_t        exp_q[$];
    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;
    bit          rnd_ready = 1'b0;
    logic [7:0]  lfsr = 8'hA5;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];

    affine_trace_walker #(.ADDR_W(ADDR_W), .DST_W(DST_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .stat_word(stat_word), .busy(busy),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_src_x(pix_src_x),
        .pix_src_y(pix_src_y), .pix_dst(pix_dst)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            chk(1'b0, "R5", "watchdog expired", cycles, 100000);
            finish_run();
        end
    end

    // Ready driver, moved just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            pix_ready = rnd_ready ? (lfsr[0] | lfsr[2]) : 1'b1;
        end
    end

    // Monitor: pops expected pixels on each handshake (R2, R3, R4, R9)
    pix_t prev_pix;
    bit   prev_stall = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                chk(pix_valid && pix_src_x == prev_pix.x && pix_src_y == prev_pix.y &&
                    pix_dst == prev_pix.d, "R6", "output held under stall",
                    {pix_valid, pix_src_x}, {1'b1, prev_pix.x});
            end
            prev_stall = pix_valid && !pix_ready;
            prev_pix   = '{x: pix_src_x, y: pix_src_y, d: pix_dst};
            if (pix_valid && pix_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4", "unexpected pixel", pix_dst, 0);
                end else begin
                    pix_t e;
                    e = exp_q.pop_front();
                    chk(pix_src_x == e.x, "R3", "source x", pix_src_x, e.x);
                    chk(pix_src_y == e.y, "R3", "source y", pix_src_y, e.y);
                    chk(pix_dst == e.d, "R9", "destination index", pix_dst, e.d);
                end
            end
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    function automatic logic [23:0] step_acc(input logic [23:0] a, input logic [15:0] d);
        // R3: sign-magnitude, bit 15 sign, bits 14:0 magnitude
        if (d[15]) return a - {9'd0, d[14:0]};
        return a + {9'd0, d[14:0]};
    endfunction

    // Driver: program and push expectations. R1 word order sx, sy, dx, dy.
    task automatic push_expected(input int base, input int w, input int h, input int off);
        int dst = off;
        for (int l = 0; l < h; l++) begin
            logic [23:0] ax, ay;
            int a = base + 4*l;
            ax = {mem[a], 8'd0};       // R2
            ay = {mem[a+1], 8'd0};
            for (int p = 0; p < w; p++) begin
                exp_q.push_back('{x: ax[23:11], y: ay[23:11], d: DST_W'(dst)});
                ax = step_acc(ax, mem[a+2]);
                ay = step_acc(ay, mem[a+3]);
                dst++;
            end
        end
    endtask

    task automatic wait_done();
        int n = 0;
        while (busy && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(!busy, "R5", "busy cleared after last line", busy, 0);
        chk(exp_q.size() == 0, "R5", "all pixels emitted", exp_q.size(), 0);
        chk(stat_word == 16'h0000, "R7", "status idle", stat_word, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        // Walk A at base 0x10
        mem[8'h10] = 16'd80;   mem[8'h11] = 16'd160; mem[8'h12] = 16'h0800; mem[8'h13] = 16'h0000;
        mem[8'h14] = 16'h0013; mem[8'h15] = 16'h000F; mem[8'h16] = 16'h7FFF; mem[8'h17] = 16'h0123;
        mem[8'h18] = 16'h0100; mem[8'h19] = 16'h0200; mem[8'h1A] = 16'h8123; mem[8'h1B] = 16'h8800;
        // Walk B at base 0x40, wrap cases
        mem[8'h40] = 16'h0000; mem[8'h41] = 16'h0320; mem[8'h42] = 16'h8800; mem[8'h43] = 16'h0400;
        mem[8'h44] = 16'h002C; mem[8'h45] = 16'h0008; mem[8'h46] = 16'h0C00; mem[8'h47] = 16'h8200;
        mem[8'h48] = 16'hFFF8; mem[8'h49] = 16'h0000; mem[8'h4A] = 16'h0800; mem[8'h4B] = 16'h8001;
        // Decoy at 0x80: a restart here would show up as wrong data
        for (int i = 8'h80; i < 8'h90; i++) mem[i] = 16'h5555;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: reset state
        chk(busy == 1'b0, "R7", "busy after reset", busy, 0);
        chk(stat_word == 16'h0000, "R7", "status after reset", stat_word, 0);
        chk(!pix_valid && !mem_rd, "R7", "quiet after reset", {pix_valid, mem_rd}, 0);

        // R11: zero height blocks launch
        cfg_write(2'd0, 16'd5);
        cfg_write(2'd1, 16'd0);
        cfg_write(2'd3, 16'h0010);
        begin
            bit quiet = 1'b1;
            for (int i = 0; i < 20; i++) begin
                if (busy || mem_rd || pix_valid) quiet = 1'b0;
                @(negedge clk);
            end
            chk(quiet, "R11", "no launch with zero height", !quiet, 0);
        end

        // Walk A: ready always high, latency check (R8)
        cfg_write(2'd1, 16'd3);
        cfg_write(2'd2, 16'd100);
        push_expected(16'h10, 5, 3, 100);
        cfg_write(2'd3, 16'h0010);
        chk(busy && stat_word == 16'h8000, "R7", "status busy bit", stat_word, 16'h8000);
        chk(mem_rd && mem_addr == 16'h0010, "R1", "first read address", mem_addr, 16'h10);
        begin
            int n = 1;
            while (!pix_valid && n < 40) begin
                @(negedge clk);
                n++;
            end
            chk(n == 13, "R8", "first pixel latency", n, 13);
        end
        wait_done();

        // Walk B: random stalls, disturbing writes while busy (R10)
        rnd_ready = 1'b1;
        cfg_write(2'd0, 16'd4);
        cfg_write(2'd1, 16'd3);
        cfg_write(2'd2, 16'd7);
        push_expected(16'h40, 4, 3, 7);
        cfg_write(2'd3, 16'h0040);
        repeat (5) @(negedge clk);
        cfg_write(2'd3, 16'h0080);
        cfg_write(2'd0, 16'd2);
        cfg_write(2'd2, 16'd900);
        chk(busy, "R10", "still busy after ignored base write", busy, 1);
        wait_done();
        rnd_ready = 1'b0;

        // Walk C: width 2 latched from the write made during walk B (R10, R4)
        cfg_write(2'd1, 16'd1);
        push_expected(16'h10, 2, 1, 900);
        cfg_write(2'd3, 16'h0010);
        wait_done();

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule